// File: doc/BRIEF.md
# PWM Trip and Period Interrupt Controller

This block sits next to a four-pair PWM generator and turns two kinds of event into interrupt requests. The first kind is a period wrap: a pair's counter goes from its programmed period value straight to 0. The second kind is a protection trip: an active-low fault pin falls. Each event sets a sticky flag, and the flag drives an interrupt line at a steady level. Software clears a flag by writing a 1 to the matching bit of a clear register. A trip also produces a one-cycle pulse that the register file uses to drop the global PWM enable, so the outputs stop without waiting for software.

The counters, the period registers and the control bits all come from outside the block and are only observed here. The trip pin is asynchronous and passes through a two-stage synchronizer before edge detection. In bridge mode the four pairs act as one driver, so only pair 0 may raise a period interrupt. Every pin is a plain control or status signal: no data streams through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pwm_trip_irq`

## Requirements
- R1: With trip enabled, a falling edge on `trip_n_i` sets `trip_irq_o` and gives a single-cycle `en_clr_o` pulse, both high after the third rising clock edge that samples the low level.
- R2: With `trip_en_i` low, a falling trip input sets no flag and gives no `en_clr_o` pulse.
- R3: Writing a 1 to bit 4 of `clr_data_i` while `clr_we_i` is high clears `trip_irq_o` on the next edge. A trip pin that stays low does not set the flag again.
- R4: When `irq_en_i` is high and pair n's counter is 0 in a cycle where it held `period_i` of that pair in the previous cycle, `pair_irq_o[n]` is high after that edge.
- R5: Writing a 1 to bit n (n = 0..3) of `clr_data_i` with `clr_we_i` high clears `pair_irq_o[n]` and leaves the other flags unchanged.
- R6: When `bridge_i` is high, only pair 0 can set its interrupt. Wraps on pairs 1 to 3 are ignored.
- R7: If a set event and a clear write reach the same flag in one cycle, the flag ends up set.
- R8: Flags stay set until they are cleared. A clear write whose bits are 0 leaves every flag unchanged. All flags and `en_clr_o` are 0 after reset.
- R9: The trip flag does not depend on `irq_en_i`.
- R10: No pair interrupt is raised when `irq_en_i` is low, or when the counter reaches 0 from a value other than its period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 64 | Counters of pairs 0..3, 16 bits each, with pair 0 in the low bits |
| period_i | input | 64 | Period values of pairs 0..3, packed in the same way |
| trip_n_i | input | 1 | Asynchronous fault input, active low |
| trip_en_i | input | 1 | Enables trip detection |
| irq_en_i | input | 1 | Enables period interrupts |
| bridge_i | input | 1 | Bridge mode: only pair 0 can interrupt |
| clr_we_i | input | 1 | Write strobe for the clear register |
| clr_data_i | input | 5 | Clear bits: bits 0..3 for pairs, bit 4 for trip |
| pair_irq_o | output | 4 | Period interrupt levels, one per pair |
| trip_irq_o | output | 1 | Trip interrupt level |
| en_clr_o | output | 1 | One-cycle pulse that drops the global PWM enable |

## Verification
The bench drives a counter to 0 from a value other than its period. A design that flagged every zero would raise a false interrupt there. It lines up a wrap or a trip in the same cycle as a clear of that flag; a design where the clear wins would lose the event. It runs wraps on all pairs in bridge mode, where a missing mask would raise pairs 1 to 3. It also checks the exact cycle of the trip pulse, its one-cycle width, and that a pin held low does not set the flag again once cleared. Wrong synchronizer depth or a level-sensitive trip would show up in those checks.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;
  localparam int unsigned PAIRS_DEF  = 4;
  localparam int unsigned CNT_W_DEF  = 16;
  localparam int unsigned SYNC_DEF   = 2;
  // clear-register layout: pair bits first, trip bit directly above them
  function automatic int unsigned trip_clr_idx(input int unsigned pairs);
    return pairs;
  endfunction
endpackage

// File: rtl/pwm_trip_sync.sv
module pwm_trip_sync #(
  parameter int unsigned STAGES = pwm_trip_pkg::SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_n_i,
  input  logic trip_en_i,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  // chain resets to the idle (high) level so no edge appears after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], trip_n_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign fall_o = trip_en_i && last_q && !chain_q[STAGES-1];

  // R2: no edge reported while detection is disabled
  assert_trip_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_en_i |-> !fall_o);
endmodule

// File: rtl/pwm_wrap_detect.sv
module pwm_wrap_detect #(
  parameter int unsigned CNT_W = pwm_trip_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             gate_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] prev_q;
  logic             prev_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else begin
      prev_q     <= cnt_i;
      prev_vld_q <= 1'b1;
    end
  end

  assign wrap_o = gate_i && prev_vld_q && (prev_q == period_i) && (cnt_i == '0);

  // R10: a wrap is only reported when the counter arrives at zero
  assert_wrap_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> (cnt_i == '0) && gate_i);
endmodule

// File: rtl/pwm_sticky_flag.sv
module pwm_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/pwm_trip_irq.sv
module pwm_trip_irq #(
  parameter int unsigned PAIRS  = pwm_trip_pkg::PAIRS_DEF,
  parameter int unsigned CNT_W  = pwm_trip_pkg::CNT_W_DEF,
  parameter int unsigned STAGES = pwm_trip_pkg::SYNC_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PAIRS*CNT_W-1:0] cnt_i,
  input  logic [PAIRS*CNT_W-1:0] period_i,
  input  logic                   trip_n_i,
  input  logic                   trip_en_i,
  input  logic                   irq_en_i,
  input  logic                   bridge_i,
  input  logic                   clr_we_i,
  input  logic [PAIRS:0]         clr_data_i,
  output logic [PAIRS-1:0]       pair_irq_o,
  output logic                   trip_irq_o,
  output logic                   en_clr_o
);
  localparam int unsigned TRIP_BIT = pwm_trip_pkg::trip_clr_idx(PAIRS);

  logic [PAIRS-1:0] wrap;
  logic             trip_fall;

  // per-pair wrap detection and sticky status
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic gate;
    // only pair 0 survives bridge mode
    if (p == 0) begin : g_lead
      assign gate = irq_en_i;
    end else begin : g_follow
      assign gate = irq_en_i && !bridge_i;
    end

    pwm_wrap_detect #(.CNT_W(CNT_W)) u_wrap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_i    (cnt_i[p*CNT_W +: CNT_W]),
      .period_i (period_i[p*CNT_W +: CNT_W]),
      .gate_i   (gate),
      .wrap_o   (wrap[p])
    );

    pwm_sticky_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (wrap[p]),
      .clr_i  (clr_we_i && clr_data_i[p]),
      .flag_o (pair_irq_o[p])
    );

    if (p != 0) begin : g_chk
      // R6: a follower pair never rises while bridge mode is on
      assert_bridge_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bridge_i && !pair_irq_o[p]) |=> !pair_irq_o[p]);
    end
  end

  pwm_trip_sync #(.STAGES(STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .trip_n_i  (trip_n_i),
    .trip_en_i (trip_en_i),
    .fall_o    (trip_fall)
  );

  pwm_sticky_flag u_trip_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (trip_fall),
    .clr_i  (clr_we_i && clr_data_i[TRIP_BIT]),
    .flag_o (trip_irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_clr_o <= 1'b0;
    else        en_clr_o <= trip_fall;
  end

  assert_trip_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_o |-> trip_irq_o);
  assert_pulse_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_o |=> !en_clr_o);
  assert_no_irq_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en_i && pair_irq_o == '0) |=> pair_irq_o == '0);
endmodule

// File: tb/pwm_trip_irq_tb.sv
`timescale 1ns/1ps
module pwm_trip_irq_tb;
  typedef struct {
    logic [3:0] pairs;
    logic       trip;
    logic       enclr;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt [4];
  logic [15:0] per [4];
  logic        trip_n = 1'b1, trip_en = 1'b0, irq_en = 1'b0, bridge = 1'b0;
  logic        clr_we = 1'b0;
  logic [4:0]  clr_data = '0;
  logic [3:0]  pair_irq;
  logic        trip_irq, en_clr;

  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_trip_irq u_dut (
    .clk(clk), .rst_n(rst_n),
    .cnt_i({cnt[3], cnt[2], cnt[1], cnt[0]}),
    .period_i({per[3], per[2], per[1], per[0]}),
    .trip_n_i(trip_n), .trip_en_i(trip_en), .irq_en_i(irq_en), .bridge_i(bridge),
    .clr_we_i(clr_we), .clr_data_i(clr_data),
    .pair_irq_o(pair_irq), .trip_irq_o(trip_irq), .en_clr_o(en_clr)
  );

  // monitor: compares queued expectations just after each falling edge
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (pair_irq !== e.pairs || trip_irq !== e.trip || en_clr !== e.enclr) begin
        bad++;
        $display("FAIL %s: got pairs=%b trip=%b enclr=%b, expected pairs=%b trip=%b enclr=%b",
                 e.tag, pair_irq, trip_irq, en_clr, e.pairs, e.trip, e.enclr);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic [3:0] p, input logic t, input logic e, input string tag);
    exp_t x;
    x.pairs = p; x.trip = t; x.enclr = e; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic set_all(input logic [3:0] mask, input bit to_period);
    for (int i = 0; i < 4; i++) if (mask[i]) cnt[i] = to_period ? per[i] : 16'd0;
  endtask

  task automatic wrap(input logic [3:0] mask);
    set_all(mask, 1'b1); step(1);
    set_all(mask, 1'b0); step(1);
  endtask

  task automatic clear(input logic [4:0] bits);
    clr_we = 1'b1; clr_data = bits; step(1);
    clr_we = 1'b0; clr_data = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      cnt[i] = 16'd3;
      per[i] = 16'(10 * (i + 1));
    end
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_out(4'h0, 0, 0, "R8 reset");
    step(1);

    irq_en = 1'b1;
    wrap(4'hF);
    expect_out(4'hF, 0, 0, "R4 wrap all pairs");
    step(1);
    expect_out(4'hF, 0, 0, "R8 flags sticky");

    clear(5'b00000);
    expect_out(4'hF, 0, 0, "R8 zero clear bits");
    clear(5'b00101);
    expect_out(4'hA, 0, 0, "R5 clear pairs 0,2");
    clear(5'b10000);
    expect_out(4'hA, 0, 0, "R5 trip bit leaves pairs");
    clear(5'b01010);
    expect_out(4'h0, 0, 0, "R5 clear pairs 1,3");

    set_all(4'hF, 1'b0); for (int i = 0; i < 4; i++) cnt[i] = 16'd5;
    step(1);
    set_all(4'hF, 1'b0); step(1);
    expect_out(4'h0, 0, 0, "R10 zero from non-period");

    irq_en = 1'b0;
    wrap(4'hF);
    expect_out(4'h0, 0, 0, "R10 irq disabled");
    irq_en = 1'b1;

    bridge = 1'b1;
    wrap(4'hF);
    expect_out(4'h1, 0, 0, "R6 bridge keeps pair0 only");
    clear(5'b01111);
    bridge = 1'b0;
    expect_out(4'h0, 0, 0, "R5 clear after bridge");

    set_all(4'h2, 1'b1); step(1);
    set_all(4'h2, 1'b0);
    clr_we = 1'b1; clr_data = 5'b00010; step(1);
    clr_we = 1'b0; clr_data = '0;
    expect_out(4'h2, 0, 0, "R7 set beats clear pair1");
    clear(5'b00010);
    expect_out(4'h0, 0, 0, "R5 pair1 cleared");

    // trip path, period interrupts off to show independence
    irq_en = 1'b0; trip_en = 1'b1;
    trip_n = 1'b0;
    step(2);
    expect_out(4'h0, 0, 0, "R1 not before third edge");
    step(1);
    expect_out(4'h0, 1, 1, "R1 R9 trip flag and pulse");
    step(1);
    expect_out(4'h0, 1, 0, "R1 pulse one cycle");
    clear(5'b10000);
    expect_out(4'h0, 0, 0, "R3 trip cleared");
    step(3);
    expect_out(4'h0, 0, 0, "R3 held low no retrigger");
    trip_n = 1'b1; step(4);

    trip_en = 1'b0; trip_n = 1'b0; step(4);
    expect_out(4'h0, 0, 0, "R2 trip disabled");
    trip_n = 1'b1; step(4);

    trip_en = 1'b1; trip_n = 1'b0; step(2);
    clr_we = 1'b1; clr_data = 5'b10000; step(1);
    clr_we = 1'b0; clr_data = '0;
    expect_out(4'h0, 1, 1, "R7 set beats clear trip");
    clear(5'b10000);
    expect_out(4'h0, 0, 0, "R3 trip cleared again");

    step(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule